// File: doc/BRIEF.md
# Multi-Channel Reload Watchdog Timer

This block is a watchdog timer. A down-counter is clocked by a slow reference tick. When it runs out, the block raises a timeout event and then issues a reset request. Software arms the watchdog once through a start register. From then on the watchdog cannot be stopped. The reload value, the channel enable mask and the pause configuration are frozen from the moment it starts.

The counter is restarted only through a group of eight reload channels. Each enabled channel must receive an exact 32-bit key. The counter reloads on the write that completes the set of enabled channels, and the per-channel request flags then clear for the next period. Two pause inputs, one for CPU sleep and one for debugger halt, stop the count unless the configuration lets the counter keep running in that state.

Registers sit on a simple word-addressed write port with a combinational read port. The timeout event can drive an interrupt through a set/clear enable. A one-cycle reset request follows two reference ticks after the event, which gives the handler a short window first.

Top module: `multi_reload_wdt`

## Requirements
- R1: After reset the block reads as follows. Run status (addr 4) is 0, event (addr 1) is 0, interrupt enable is 0, reload value (addr 6) is 0xFFFFFFFF, enable mask (addr 7) is 0x01, configuration (addr 8) is 0, and request status (addr 5) is 0x01. `irq_o` and `rst_req_o` are low.
- R2: Writing a value with bit 0 set to addr 0 starts the watchdog and sets run status bit 0. No later write stops it.
- R3: With reload value V, the timeout event (addr 1 bit 0) sets on the (V+1)-th counted tick after start or after the last reload. After an expiry the counter restarts from V and keeps counting.
- R4: A channel request is recorded only when the watchdog is running and exactly 0x6E524635 is written to that channel's register (addr 16+n). Other values, writes to disabled channels, and writes made before start are ignored.
- R5: The counter reloads to V on the write that leaves every enabled channel requested. At that point all request flags clear. While any enabled channel is still missing, no reload takes place.
- R6: Request status bit n reads 1 when channel n is enabled and has not requested since the last reload. Otherwise it reads 0.
- R7: While `sleep_i` is high, counting pauses unless configuration bit 0 is 1. While `halt_i` is high, counting pauses unless configuration bit 3 is 1.
- R8: Writing 1 to bit 0 of addr 2 sets the interrupt enable, and writing 1 to bit 0 of addr 3 clears it. Writing 0 to either has no effect. Both addresses read the enable. `irq_o` equals event AND enable. Writing bit 0 of addr 1 sets the event flag to that value, and an expiry takes priority over the write.
- R9: `rst_req_o` pulses high for one clock at the second reference tick after the first timeout event. It pulses only once.
- R10: While the watchdog runs, writes to the reload value, enable mask and configuration are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock pulse per reference period |
| sleep_i | input | 1 | CPU is sleeping |
| halt_i | input | 1 | CPU is halted by the debugger |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Timeout interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The embedded assertions check several properties on every cycle:
- the run flag cannot fall;
- the locked registers do not change while running;
- an expiry always raises the event and restarts the counter from the reload value;
- flags clear after a reload;
- the counter holds when not counting;
- the reset pulse is a single cycle that follows an armed delay.

Other behaviours can only be shown by the bench's scenarios. These are the exact expiry tick for each reload value, the full pause matrix across configuration and input states, and key tracking across several enable masks and write orders. They also include key rejection before start and the two-tick reset spacing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_START    = 5'd0;
  localparam logic [ADDR_W-1:0] A_EVT      = 5'd1;
  localparam logic [ADDR_W-1:0] A_IE_SET   = 5'd2;
  localparam logic [ADDR_W-1:0] A_IE_CLR   = 5'd3;
  localparam logic [ADDR_W-1:0] A_RUN      = 5'd4;
  localparam logic [ADDR_W-1:0] A_REQ      = 5'd5;
  localparam logic [ADDR_W-1:0] A_RELOAD   = 5'd6;
  localparam logic [ADDR_W-1:0] A_CHEN     = 5'd7;
  localparam logic [ADDR_W-1:0] A_CFG      = 5'd8;
  localparam logic [ADDR_W-1:0] A_KEY_BASE = 5'd16;

  localparam logic [31:0] WDT_KEY = 32'h6E52_4635;

  localparam int unsigned CFG_SLEEP_BIT = 0;
  localparam int unsigned CFG_HALT_BIT  = 3;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = dec_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i || expire_o)  cnt_q <= load_val_i;
    else if (dec_i)               cnt_q <= cnt_q - 1'b1;
  end

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_i && !load_i) |=> $stable(cnt_q));

  p_expire_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/wdt_chan_track.sv
module wdt_chan_track #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] key_hit_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic              reload_o
);
  logic [NUM_CH-1:0] flag_q, hit, flag_set;

  assign hit      = key_hit_i & en_i;
  assign flag_set = flag_q | hit;
  // reload fires on the write that completes the enabled set
  assign reload_o = (|hit) && ((flag_set & en_i) == en_i);
  assign pend_o   = en_i & ~flag_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[g] <= 1'b0;
      else if (reload_o) flag_q[g] <= 1'b0;
      else               flag_q[g] <= flag_set[g];
    end
  end

  p_clear_after_reload_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> (flag_q == '0));

  p_no_reload_partial_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((flag_q | key_hit_i) & en_i) != en_i) |-> !reload_o);
endmodule

// File: rtl/wdt_rst_seq.sv
module wdt_rst_seq #(
  parameter int unsigned RST_DLY = 2,
  localparam int unsigned DLY_W  = $clog2(RST_DLY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic tick_i,
  output logic rst_req_o
);
  logic             armed_q, fired_q, pulse_q;
  logic [DLY_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      fired_q <= 1'b0;
      pulse_q <= 1'b0;
      left_q  <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (expire_i && !armed_q && !fired_q) begin
        armed_q <= 1'b1;
        left_q  <= DLY_W'(RST_DLY);
      end else if (armed_q && tick_i) begin
        left_q <= left_q - 1'b1;
        if (left_q == DLY_W'(1)) begin
          pulse_q <= 1'b1;
          armed_q <= 1'b0;
          fired_q <= 1'b1;
        end
      end
    end
  end

  assign rst_req_o = pulse_q;

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  p_pulse_after_arm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |-> $past(armed_q && tick_i));
endmodule

// File: rtl/multi_reload_wdt.sv
module multi_reload_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned RST_DLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sleep_i,
  input  logic              halt_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic              run_q, evt_q, ie_q, cfg_sleep_q, cfg_halt_q;
  logic [CNT_W-1:0]  reload_q;
  logic [NUM_CH-1:0] chen_q, key_hit, pend;
  logic              chan_reload, expire, start, load, pause, dec;

  function automatic logic wr_at(logic [ADDR_W-1:0] a);
    return wr_i && (addr_i == a);
  endfunction

  assign start = wr_at(A_START) && wdata_i[0] && !run_q;
  assign load  = start || chan_reload;
  assign pause = (sleep_i && !cfg_sleep_q) || (halt_i && !cfg_halt_q);
  assign dec   = run_q && tick_i && !pause;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_key
    assign key_hit[g] = run_q && wr_at(A_KEY_BASE + ADDR_W'(g)) && (wdata_i == WDT_KEY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      evt_q       <= 1'b0;
      ie_q        <= 1'b0;
      reload_q    <= '1;
      chen_q      <= NUM_CH'(1);
      cfg_sleep_q <= 1'b0;
      cfg_halt_q  <= 1'b0;
    end else begin
      if (start) run_q <= 1'b1;
      if (expire)              evt_q <= 1'b1;
      else if (wr_at(A_EVT))   evt_q <= wdata_i[0];
      if (wr_at(A_IE_SET) && wdata_i[0]) ie_q <= 1'b1;
      if (wr_at(A_IE_CLR) && wdata_i[0]) ie_q <= 1'b0;
      if (!run_q) begin
        if (wr_at(A_RELOAD)) reload_q <= wdata_i[CNT_W-1:0];
        if (wr_at(A_CHEN))   chen_q   <= wdata_i[NUM_CH-1:0];
        if (wr_at(A_CFG)) begin
          cfg_sleep_q <= wdata_i[CFG_SLEEP_BIT];
          cfg_halt_q  <= wdata_i[CFG_HALT_BIT];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_EVT:               rdata_o[0] = evt_q;
      A_IE_SET, A_IE_CLR:  rdata_o[0] = ie_q;
      A_RUN:               rdata_o[0] = run_q;
      A_REQ:               rdata_o[NUM_CH-1:0] = pend;
      A_RELOAD:            rdata_o[CNT_W-1:0]  = reload_q;
      A_CHEN:              rdata_o[NUM_CH-1:0] = chen_q;
      A_CFG: begin
        rdata_o[CFG_SLEEP_BIT] = cfg_sleep_q;
        rdata_o[CFG_HALT_BIT]  = cfg_halt_q;
      end
      default:             rdata_o = '0;
    endcase
  end

  assign irq_o = evt_q && ie_q;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(reload_q), .dec_i(dec), .expire_o(expire)
  );

  wdt_chan_track #(.NUM_CH(NUM_CH)) u_chan (
    .clk_i, .rst_ni, .en_i(chen_q), .key_hit_i(key_hit), .pend_o(pend), .reload_o(chan_reload)
  );

  wdt_rst_seq #(.RST_DLY(RST_DLY)) u_rst (
    .clk_i, .rst_ni, .expire_i(expire), .tick_i, .rst_req_o
  );

  p_run_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);

  p_cfg_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> ($stable(reload_q) && $stable(chen_q) && $stable(cfg_sleep_q) && $stable(cfg_halt_q)));

  p_evt_on_expiry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> evt_q);

  p_idle_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (pend == chen_q));

  p_idle_no_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !rst_req_o);
endmodule

// File: tb/multi_reload_wdt_bench.sv
module multi_reload_wdt_bench;
  import wdt_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0, sleep_i = 1'b0, halt_i = 1'b0, wr_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, rst_req_o;
  int          n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  multi_reload_wdt u_multi_reload_wdt (
    .clk_i, .rst_ni, .tick_i, .sleep_i, .halt_i, .wr_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .rst_req_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; tick_i = 0; sleep_i = 0; halt_i = 0; wr_i = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic tick();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  function automatic int top_bit(input logic [7:0] m);
    int t = -1;
    for (int i = 0; i < 8; i++) if (m[i]) t = i;
    return t;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  masks [5];
    masks = '{8'h01, 8'h05, 8'hA0, 8'hFF, 8'h3C};

    // R1 reset state
    do_reset();
    rd(A_RUN, d);    chk("R1 run", d, 0);
    rd(A_EVT, d);    chk("R1 evt", d, 0);
    rd(A_IE_SET, d); chk("R1 ie", d, 0);
    rd(A_RELOAD, d); chk("R1 reload", d, 32'hFFFF_FFFF);
    rd(A_CHEN, d);   chk("R1 chen", d, 1);
    rd(A_CFG, d);    chk("R1 cfg", d, 0);
    rd(A_REQ, d);    chk("R1 req", d, 1);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 rst_req", {31'd0, rst_req_o}, 0);

    // R3 / R9: expiry tick and reset spacing per reload value
    for (int v = 0; v <= 5; v++) begin
      int rem;
      do_reset();
      wr(A_RELOAD, v);
      rd(A_RELOAD, d); chk("R10 writable idle", d, v);
      wr(A_START, 1);
      rd(A_RUN, d); chk("R2 running", d, 1);
      for (int k = 1; k <= v + 1; k++) begin
        tick();
        rd(A_EVT, d);
        chk("R3 expiry tick", d, (k == v + 1) ? 1 : 0);
      end
      chk("R9 no reset at event", {31'd0, rst_req_o}, 0);
      tick();
      chk("R9 no reset one tick", {31'd0, rst_req_o}, 0);
      tick();
      chk("R9 reset two ticks", {31'd0, rst_req_o}, 1);
      @(negedge clk_i);
      chk("R9 single pulse", {31'd0, rst_req_o}, 0);
      wr(A_EVT, 0);
      rem = ((2 % (v + 1)) == 0) ? (v + 1) : (v + 1) - (2 % (v + 1));
      for (int k = 1; k < rem; k++) tick();
      rd(A_EVT, d); chk("R3 restart not yet", d, 0);
      tick();
      rd(A_EVT, d); chk("R3 restart expiry", d, 1);
      tick(); tick();
      chk("R9 only once", {31'd0, rst_req_o}, 0);
    end

    // R7 pause matrix
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 4; s++) begin
        logic exp_cnt;
        exp_cnt = !((s[0] && !c[0]) || (s[1] && !c[1]));
        do_reset();
        wr(A_RELOAD, 0);
        wr(A_CFG, (c[1] << 3) | c[0]);
        wr(A_START, 1);
        @(negedge clk_i);
        sleep_i = s[0]; halt_i = s[1];
        tick();
        rd(A_EVT, d); chk("R7 pause matrix", d, {31'd0, exp_cnt});
        sleep_i = 0; halt_i = 0;
      end
    end

    // R4 / R5 / R6 channel tracking
    foreach (masks[i]) begin
      logic [7:0] m;
      int hb;
      m = masks[i];
      hb = top_bit(m);
      do_reset();
      wr(A_RELOAD, 3);
      wr(A_CHEN, m);
      wr(A_KEY_BASE + 5'(hb), WDT_KEY);
      wr(A_START, 1);
      rd(A_REQ, d); chk("R4 key before start ignored", d, m);
      tick(); tick();
      for (int ch = 0; ch < 8; ch++) begin
        if (m[ch]) wr(A_KEY_BASE + 5'(ch), WDT_KEY ^ 32'h1);
        else       wr(A_KEY_BASE + 5'(ch), WDT_KEY);
      end
      rd(A_REQ, d); chk("R4 bad key or disabled ignored", d, m);
      for (int ch = 0; ch < hb; ch++) if (m[ch]) wr(A_KEY_BASE + 5'(ch), WDT_KEY);
      rd(A_REQ, d); chk("R6 pending status", d, 32'(1) << hb);
      tick(); tick();
      rd(A_EVT, d); chk("R5 partial no reload", d, 1);

      do_reset();
      wr(A_RELOAD, 3);
      wr(A_CHEN, m);
      wr(A_START, 1);
      tick(); tick();
      for (int ch = 0; ch < 8; ch++) if (m[ch]) wr(A_KEY_BASE + 5'(ch), WDT_KEY);
      rd(A_REQ, d); chk("R5 flags cleared", d, m);
      tick(); tick(); tick();
      rd(A_EVT, d); chk("R5 reloaded not expired", d, 0);
      tick();
      rd(A_EVT, d); chk("R5 reloaded expiry", d, 1);
    end

    // R8 interrupt / R2 / R10 locks
    do_reset();
    wr(A_RELOAD, 0);
    wr(A_START, 1);
    tick();
    chk("R8 irq masked", {31'd0, irq_o}, 0);
    wr(A_IE_SET, 0);
    rd(A_IE_SET, d); chk("R8 set zero no effect", d, 0);
    wr(A_IE_SET, 1);
    chk("R8 irq enabled", {31'd0, irq_o}, 1);
    rd(A_IE_CLR, d); chk("R8 clr reads enable", d, 1);
    wr(A_IE_CLR, 0);
    chk("R8 clr zero no effect", {31'd0, irq_o}, 1);
    wr(A_IE_CLR, 1);
    chk("R8 irq cleared", {31'd0, irq_o}, 0);
    wr(A_IE_SET, 1);
    wr(A_EVT, 0);
    chk("R8 event cleared", {31'd0, irq_o}, 0);
    wr(A_START, 0);
    rd(A_RUN, d); chk("R2 cannot stop", d, 1);
    wr(A_RELOAD, 7);
    rd(A_RELOAD, d); chk("R10 reload locked", d, 0);
    wr(A_CHEN, 8'hFF);
    rd(A_CHEN, d); chk("R10 chen locked", d, 1);
    wr(A_CFG, 9);
    rd(A_CFG, d); chk("R10 cfg locked", d, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule